// File: doc/BRIEF.md
# Vector-Programmed FIFO Word Unpacker

The block sits between a transmit FIFO and a serial protocol engine. It takes one 32-bit FIFO entry at a time and turns it into a stream of single bits. Four software-programmed packing vectors decide which bits are sent and in what order. Each vector names a start bit inside the entry, a walk direction and a run of one to eight bits. A stop flag ends the entry early.

Runs are chained in vector order, so a protocol word can be wider than eight bits and span several vectors. The same configuration also covers several short words packed into one entry. A separate word-size input sets how many bits make up one protocol word. The block raises a word-end marker on the last bit of each word. The serial side has a valid/ready handshake and stalls without losing a bit.

Top module: `vec_unpacker`

## Requirements
- R1: After the asynchronous active-low reset, `bit_valid_o` is low and `in_ready_o` is high.
- R2: Each 10-bit vector is laid out as bit 0 stop, bits 3:1 run length minus one, bit 4 direction, bits 9:5 start index. `cfg0_i` holds vector 0 in bits 9:0 and vector 1 in bits 19:10. `cfg1_i` holds vectors 2 and 3 in the same positions. The configuration inputs stay steady while an entry is held.
- R3: With direction 1, a run reads the start index and then successively lower bit positions. With direction 0, it reads successively higher positions. Positions wrap modulo 32.
- R4: Vectors are used in order starting at vector 0. Each vector emits exactly its run length in bits, one bit per accepted output cycle.
- R5: The first vector with its stop flag set is the last one used for the entry. When its last bit is accepted, the entry is released, and `in_ready_o` is high in the next cycle.
- R6: If vectors 0 to 2 have no stop flag, vector 3 is the last one used, whatever its own stop flag.
- R7: An entry is accepted only on a cycle with `in_valid_i` and `in_ready_o` both high. `in_ready_o` is low while an entry is held, and `in_valid_i` has no effect during that time.
- R8: While `bit_valid_o` is high and `bit_ready_i` is low, the output holds its state: `bit_valid_o`, `bit_o` and `word_end_o` keep their values into the next cycle, and no bit is skipped.
- R9: `word_end_o` is high on the output bit at which the number of bits emitted since the last word end reaches `word_bits_i` (1 to 32). The count also restarts when an entry is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg0_i | input | 32 | Packing vectors 0 and 1 |
| cfg1_i | input | 32 | Packing vectors 2 and 3 |
| word_bits_i | input | 6 | Protocol word size in bits, 1 to 32 |
| in_valid_i | input | 1 | FIFO entry valid |
| in_data_i | input | 32 | FIFO entry |
| in_ready_o | output | 1 | Block can take an entry |
| bit_o | output | 1 | Serial data bit |
| bit_valid_o | output | 1 | Serial bit valid |
| bit_ready_i | input | 1 | Downstream takes the bit |
| word_end_o | output | 1 | Current bit closes a protocol word |

## Verification
The unpacker is driven with four configurations, each of which tells apart a different class of fault:
- Four 7-bit MSB-first words per entry expose wrong start offsets and a wrong walk direction.
- Two 15-bit LSB-first words with alternating 8/7-bit runs show that runs are chained across vectors and that word ends follow the word size rather than run boundaries.
- A 23-bit word with the stop flag on vector 2 separates early termination from a fixed four-vector walk.
- A table with no stop flag, a wrapping start index and a 5-bit word size checks the fallback to vector 3, wrap-around addressing, and the word counter restart at entry boundaries.

Downstream ready is held high, alternated and driven pseudo-randomly to expose lost or repeated bits. A phase with `in_valid_i` held high with other data while an entry is busy shows that the held entry is not overwritten.

// File: rtl/vu_pkg.sv
package vu_pkg;
  localparam int unsigned ENTRY_W   = 32;
  localparam int unsigned POS_W     = $clog2(ENTRY_W);
  localparam int unsigned NUM_VEC   = 4;
  localparam int unsigned VEC_W     = 10;
  localparam int unsigned VEC_PER_W = 2;
  localparam int unsigned RUN_W     = 3;
  localparam int unsigned VIDX_W    = $clog2(NUM_VEC);

  typedef struct packed {
    logic [POS_W-1:0] start;
    logic             dir;     // 1: toward lower positions
    logic [RUN_W-1:0] len_m1;
    logic             stop;
  } pack_vec_t;
endpackage

// File: rtl/vu_vec_walk.sv
module vu_vec_walk
  import vu_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ENTRY_W-1:0]     cfg0_i,
  input  logic [ENTRY_W-1:0]     cfg1_i,
  input  logic                   busy_i,
  input  logic                   adv_i,
  output logic [POS_W-1:0]       pos_o,
  output logic                   entry_end_o
);
  localparam int unsigned NUM_CFG = NUM_VEC / VEC_PER_W;

  logic [NUM_CFG-1:0][ENTRY_W-1:0] cfg_w;
  pack_vec_t [NUM_VEC-1:0]         vecs;
  logic [VIDX_W-1:0]               vidx_q;
  logic [RUN_W-1:0]                cnt_q;
  pack_vec_t                       cur;
  logic                            run_end, last_vec;
  logic [POS_W-1:0]                off;

  assign cfg_w[0] = cfg0_i;
  assign cfg_w[1] = cfg1_i;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vecs[v] = pack_vec_t'(cfg_w[v / VEC_PER_W][(v % VEC_PER_W) * VEC_W +: VEC_W]);
  end

  assign cur      = vecs[vidx_q];
  assign run_end  = (cnt_q == cur.len_m1);
  assign last_vec = cur.stop || (vidx_q == VIDX_W'(NUM_VEC - 1));
  assign off      = POS_W'(cnt_q);
  assign pos_o    = cur.dir ? (cur.start - off) : (cur.start + off);
  assign entry_end_o = run_end && last_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vidx_q <= '0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      if (run_end) begin
        cnt_q  <= '0;
        vidx_q <= last_vec ? '0 : vidx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (cnt_q <= cur.len_m1));
  p_first_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (vidx_q == '0 && cnt_q == '0));
endmodule

// File: rtl/vu_word_count.sv
module vu_word_count #(
  parameter int unsigned WB_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WB_W-1:0] word_bits_i,
  input  logic            adv_i,
  input  logic            clear_i,
  output logic            last_bit_o
);
  logic [WB_W-1:0] wcnt_q;

  assign last_bit_o = ((wcnt_q + 1'b1) == word_bits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       wcnt_q <= '0;
    else if (adv_i && (last_bit_o || clear_i)) wcnt_q <= '0;
    else if (adv_i)                    wcnt_q <= wcnt_q + 1'b1;
  end

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clear_i && !last_bit_o) |=> (wcnt_q == $past(wcnt_q) + 1'b1));
endmodule

// File: rtl/vec_unpacker.sv
module vec_unpacker
  import vu_pkg::*;
#(
  parameter int unsigned WB_W = POS_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRY_W-1:0] cfg0_i,
  input  logic [ENTRY_W-1:0] cfg1_i,
  input  logic [WB_W-1:0]    word_bits_i,
  input  logic               in_valid_i,
  input  logic [ENTRY_W-1:0] in_data_i,
  output logic               in_ready_o,
  output logic               bit_o,
  output logic               bit_valid_o,
  input  logic               bit_ready_i,
  output logic               word_end_o
);
  logic [ENTRY_W-1:0] data_q;
  logic               full_q;
  logic               adv, entry_end, last_bit;
  logic [POS_W-1:0]   pos;

  assign adv         = full_q && bit_ready_i;
  assign in_ready_o  = !full_q;
  assign bit_valid_o = full_q;
  assign bit_o       = data_q[pos];
  assign word_end_o  = full_q && last_bit;

  vu_vec_walk i_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg0_i      (cfg0_i),
    .cfg1_i      (cfg1_i),
    .busy_i      (full_q),
    .adv_i       (adv),
    .pos_o       (pos),
    .entry_end_o (entry_end)
  );

  vu_word_count #(.WB_W(WB_W)) i_wcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_bits_i (word_bits_i),
    .adv_i       (adv),
    .clear_i     (entry_end),
    .last_bit_o  (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (adv && entry_end) begin
      full_q <= 1'b0;
    end
  end

  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (bit_valid_o && !in_ready_o));
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && entry_end) |=> in_ready_o);
  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_ready_i) |=>
      (bit_valid_o && $stable(bit_o) && $stable(word_end_o)));
endmodule

// File: tb/test_vec_unpacker.sv
module test_vec_unpacker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg0_i = '0, cfg1_i = '0;
  logic [5:0]  word_bits_i = 6'd8;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o, bit_o, bit_valid_o, word_end_o;
  logic        bit_ready_i = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  int mw = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  vec_unpacker i_vec_unpacker (
    .clk_i, .rst_ni, .cfg0_i, .cfg1_i, .word_bits_i, .in_valid_i, .in_data_i,
    .in_ready_o, .bit_o, .bit_valid_o, .bit_ready_i, .word_end_o
  );

  function automatic logic [9:0] vec(int start, bit dir, int len, bit stop);
    logic [4:0] s = start[4:0];
    logic [2:0] l = 3'(len - 1);
    return {s, dir, l, stop};
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Expected stream of one entry, built from R2..R6 and R9.
  task automatic push_entry(logic [31:0] d);
    for (int v = 0; v < 4; v++) begin
      logic [31:0] w = (v < 2) ? cfg0_i : cfg1_i;
      logic [9:0]  vv = w[(v % 2) * 10 +: 10];
      int start = int'(vv[9:5]);
      int len   = int'(vv[3:1]) + 1;
      for (int k = 0; k < len; k++) begin
        int idx = vv[4] ? (start - k) : (start + k);
        logic we;
        idx = (idx + 64) % 32;
        mw++;
        we = (mw == int'(word_bits_i));
        if (we) mw = 0;
        exp_q.push_back({d[idx], we});
      end
      if (vv[0]) break;
    end
    mw = 0;
  endtask

  task automatic cycle(bit want_valid, logic [31:0] d, int rmode);
    bit ev;
    bit rdy;
    @(negedge clk_i);
    ev = (exp_q.size() > 0);
    chk(cur_req, bit_valid_o, ev, "bit_valid");
    chk("R7", in_ready_o, !ev, "in_ready");
    if (ev) begin
      chk(cur_req, bit_o, exp_q[0][1], "bit");
      chk("R9", word_end_o, exp_q[0][0], "word_end");
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: rdy = 1'b1;
      1: rdy = ~bit_ready_i;
      default: rdy = lfsr[0] | lfsr[3];
    endcase
    bit_ready_i = rdy;
    if (rdy && ev) void'(exp_q.pop_front());
    in_valid_i = want_valid;
    in_data_i  = d;
    if (want_valid && in_ready_o) push_entry(d);
  endtask

  task automatic send(logic [31:0] d, int rmode);
    bit sent = 0;
    while (!sent) begin
      sent = in_ready_o && (exp_q.size() == 0);
      cycle(1'b1, d, rmode);
    end
    do cycle(1'b0, '0, rmode); while (exp_q.size() > 0);
    cycle(1'b0, '0, rmode);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1", bit_valid_o, 1'b0, "bit_valid in reset");
    chk("R1", in_ready_o, 1'b1, "in_ready in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", bit_valid_o, 1'b0, "bit_valid after reset");

    // R2, R4, R5: four 7-bit words MSB first, stop on vector 3
    cur_req = "R2";
    cfg0_i = {12'h0, vec(14, 1, 7, 0), vec(6, 1, 7, 0)};
    cfg1_i = {12'h0, vec(30, 1, 7, 1), vec(22, 1, 7, 0)};
    word_bits_i = 6'd7;
    send(32'h5A3C_96E1, 0);
    cur_req = "R4";
    send(32'h0123_4567, 0);

    // R3: two 15-bit words LSB first, runs 8/7/8/7
    cur_req = "R3";
    cfg0_i = {12'h0, vec(8, 0, 7, 0), vec(0, 0, 8, 0)};
    cfg1_i = {12'h0, vec(24, 0, 7, 1), vec(16, 0, 8, 0)};
    word_bits_i = 6'd15;
    send(32'hBEEF_F00D, 0);
    send(32'h8000_7FFF, 1);

    // R5: one 23-bit word, stop on vector 2, vector 3 unused
    cur_req = "R5";
    cfg0_i = {12'h0, vec(14, 1, 8, 0), vec(22, 1, 8, 0)};
    cfg1_i = {12'h0, vec(31, 0, 8, 0), vec(6, 1, 7, 1)};
    word_bits_i = 6'd23;
    send(32'h00C3_A55A, 0);
    send(32'hFF3C_0F0F, 2);

    // R6, R9: no stop flag, wrapping start, 5-bit words cross runs
    cur_req = "R6";
    cfg0_i = {12'h0, vec(29, 0, 5, 0), vec(2, 1, 8, 0)};
    cfg1_i = {12'h0, vec(15, 0, 8, 0), vec(10, 1, 3, 0)};
    word_bits_i = 6'd5;
    send(32'hC001_D00D, 0);
    cur_req = "R9";
    send(32'h1357_9BDF, 1);

    // R8: random downstream stalls
    cur_req = "R8";
    for (int i = 0; i < 6; i++) send(32'h9E37_79B9 * (i + 1), 2);

    // R7: in_valid held with other data while busy
    cur_req = "R7";
    begin
      bit sent = 0;
      while (!sent) begin
        sent = in_ready_o && (exp_q.size() == 0);
        cycle(1'b1, 32'hA5A5_0FF0, 1);
      end
      for (int i = 0; i < 40; i++) cycle(1'b1, 32'h0F0F_3333 + i, 1);
      do cycle(1'b0, '0, 0); while (exp_q.size() > 0);
      cycle(1'b0, '0, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule